// File: doc/BRIEF.md
# Aliased Control Register with Level Interrupt

This block holds one 64-bit control word behind a small register bus that only accepts whole 8-byte transfers. The word can be updated through three neighbouring word addresses. The base address loads a new value outright. The address two above the base sets bits by OR-ing the written data into the current value. The address one above the base is a build-time choice: it either ANDs the data into the word or clears the word and ignores the data. Whichever path an update takes, only the top 16 bits survive it. The lower 48 bits are always zero.

Bit 63 of the stored word drives a level interrupt line toward an interrupt controller. Software raises the interrupt by writing that bit and drops it by clearing it. Reads return the word only at the base address. All other addresses read as zero and have no side effects.

The bus side is a two-state machine. In `ST_IDLE` the block is ready and a valid request is accepted (transition `IDLE->RESP`). If no request arrives it stays put (`IDLE->IDLE`). In `ST_RESP` it presents the response for exactly one cycle and always returns (`RESP->IDLE`).

Top module: `alias_ctrl_reg`

## Requirements
- R1: After reset the stored word is zero, `irq_out` is 0, `req_ready` is 1, `rsp_valid` is 0, and a read of the base address returns zero.
- R2: A write of size 8 to the base word address stores the write data with bits 47..0 forced to zero. A following read of the base returns that value. Read data bits 47..0 are always zero.
- R3: A write of size 8 to base+2 stores (current OR data) with bits 47..0 forced to zero.
- R4: With `THIRD_CLEARS`=0, a write of size 8 to base+1 stores (current AND data) with bits 47..0 forced to zero.
- R5: With `THIRD_CLEARS`=1, a write of size 8 to base+1 sets the word to zero whatever the data.
- R6: `irq_out` equals bit 63 of the stored word. It changes in the same cycle that the response to the updating write is presented, which is one clock after acceptance.
- R7: A read of any address other than the base, including base+1 and base+2, returns zero and leaves the word and `irq_out` unchanged.
- R8: A write to any address outside base..base+2 leaves the word and `irq_out` unchanged.
- R9: A request with `req_size` other than 8 gets `rsp_err`=1 and zero read data, and changes nothing. A request of size 8 gets `rsp_err`=0.
- R10: `req_ready` is 1 only in `ST_IDLE`. A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the one following cycle, during which `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address (byte address shifted right by 3) |
| req_size | input | SIZE_W | Transfer size in bytes |
| req_wdata | input | DATA_W | Write data, bit 63 most significant |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Size error on the answered request |
| rsp_rdata | output | DATA_W | Read data |
| irq_out | output | 1 | Level interrupt, copy of stored bit 63 |

## Verification
The interrupt update and the bus response for the same write land in the same cycle. A write that flips bit 63 must therefore show the new `irq_out` level alongside `rsp_valid` and the response fields. The bench provokes this with sweeps of loads, OR writes and AND or clear writes that toggle bit 63 in both directions. It samples the response and the interrupt together on the falling edge after acceptance, against a model held in the bench. Two instances, one per variant of the third alias, run the same stimulus so that both behaviours are judged in every vector.

// File: rtl/acr_pkg.sv
package acr_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SET   = 2'd2,
        OP_THIRD = 2'd3
    } upd_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    localparam int unsigned ACCESS_BYTES = 8;

endpackage

// File: rtl/acr_addr_decode.sv
module acr_addr_decode #(
    parameter int unsigned ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE = 16'h4020
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_plain,
    output logic              hit_third,
    output logic              hit_set
);
    localparam logic [ADDR_W-1:0] THIRD_ADDR = BASE + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SET_ADDR   = BASE + ADDR_W'(2);

    always_comb begin
        hit_plain = (addr == BASE);
        hit_third = (addr == THIRD_ADDR);
        hit_set   = (addr == SET_ADDR);
    end
endmodule

// File: rtl/acr_reg_core.sv
module acr_reg_core
    import acr_pkg::*;
#(
    parameter int unsigned DATA_W       = 64,
    parameter int unsigned KEEP_W       = 16,
    parameter bit          THIRD_CLEARS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  upd_op_e           upd_op,
    input  logic [DATA_W-1:0] upd_data,
    output logic [DATA_W-1:0] value_o,
    output logic              irq_o
);
    localparam int unsigned DROP_W = DATA_W - KEEP_W;
    localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {DROP_W{1'b0}}};

    logic [DATA_W-1:0] cur_q;
    logic              irq_q;
    logic [DATA_W-1:0] third_res;
    logic [DATA_W-1:0] raw_next;
    logic [DATA_W-1:0] next_val;

    generate
        if (THIRD_CLEARS) begin : g_third_clear
            always_comb third_res = '0;
        end else begin : g_third_and
            always_comb third_res = cur_q & upd_data;
        end
    endgenerate

    always_comb begin
        unique case (upd_op)
            OP_LOAD:  raw_next = upd_data;
            OP_SET:   raw_next = cur_q | upd_data;
            OP_THIRD: raw_next = third_res;
            default:  raw_next = cur_q;
        endcase
        next_val = raw_next & KEEP_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            irq_q <= 1'b0;
        end else if (upd_valid && (upd_op != OP_NONE)) begin
            cur_q <= next_val;
            irq_q <= next_val[DATA_W-1];
        end
    end

    assign value_o = cur_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/acr_bus_fsm.sv
module acr_bus_fsm
    import acr_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              hit_plain,
    input  logic              hit_third,
    input  logic              hit_set,
    input  logic [DATA_W-1:0] cur_val,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              upd_valid,
    output upd_op_e           upd_op
);
    bus_state_e        state_q, state_d;
    logic              accept;
    logic              size_ok;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    assign size_ok = (req_size == SIZE_W'(ACCESS_BYTES));
    assign accept  = req_valid && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs by state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    // update request toward the register core
    always_comb begin
        upd_valid = accept && req_write && size_ok;
        if (hit_plain)      upd_op = OP_LOAD;
        else if (hit_set)   upd_op = OP_SET;
        else if (hit_third) upd_op = OP_THIRD;
        else                upd_op = OP_NONE;
    end

    // response capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else if (accept) begin
            err_q   <= !size_ok;
            rdata_q <= (!req_write && size_ok && hit_plain) ? cur_val : '0;
        end
    end

    assign rsp_err   = rsp_valid && err_q;
    assign rsp_rdata = rsp_valid ? rdata_q : '0;
endmodule

// File: rtl/alias_ctrl_reg.sv
module alias_ctrl_reg
    import acr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h4020,
    parameter int unsigned DATA_W       = 64,
    parameter int unsigned KEEP_W       = 16,
    parameter int unsigned SIZE_W       = 4,
    parameter bit          THIRD_CLEARS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_out
);
    logic              hit_plain, hit_third, hit_set;
    logic              upd_valid;
    upd_op_e           upd_op;
    logic [DATA_W-1:0] cur_val;

    acr_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr      (req_addr),
        .hit_plain (hit_plain),
        .hit_third (hit_third),
        .hit_set   (hit_set)
    );

    acr_bus_fsm #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .hit_plain (hit_plain),
        .hit_third (hit_third),
        .hit_set   (hit_set),
        .cur_val   (cur_val),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .upd_valid (upd_valid),
        .upd_op    (upd_op)
    );

    acr_reg_core #(.DATA_W(DATA_W), .KEEP_W(KEEP_W), .THIRD_CLEARS(THIRD_CLEARS)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_op    (upd_op),
        .upd_data  (req_wdata),
        .value_o   (cur_val),
        .irq_o     (irq_out)
    );
endmodule

// File: rtl/acr_checker.sv
module acr_checker #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned KEEP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq_out
);
    // R10
    ready_low_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R10
    rsp_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[DATA_W-KEEP_W-1:0] == '0));

    // R9
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    // R9
    err_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> $stable(irq_out));

    // R6
    irq_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_out) |-> $past(req_valid && req_ready && req_write));
endmodule

bind alias_ctrl_reg acr_checker #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .irq_out   (irq_out)
);

// File: tb/sim_alias_ctrl_reg.sv
module sim_alias_ctrl_reg;
    localparam logic [15:0] B    = 16'h4020;
    localparam logic [63:0] MASK = 64'hFFFF_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_size = 4'd8;
    logic [63:0] req_wdata = '0;

    logic        rdy_a, rv_a, err_a, irq_a;
    logic        rdy_c, rv_c, err_c, irq_c;
    logic [63:0] rd_a, rd_c;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [63:0] exp_a = '0;
    logic [63:0] exp_c = '0;

    always #2.5 clk = ~clk;

    alias_ctrl_reg #(.BASE(B), .THIRD_CLEARS(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rv_a), .rsp_err(err_a),
        .rsp_rdata(rd_a), .irq_out(irq_a));

    alias_ctrl_reg #(.BASE(B), .THIRD_CLEARS(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_c),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rv_c), .rsp_err(err_c),
        .rsp_rdata(rd_c), .irq_out(irq_c));

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus transfer on both instances; tag names the requirement under test
    task automatic xfer(bit wr, logic [15:0] a, logic [3:0] sz, logic [63:0] d, string tag);
        logic [63:0] ra, rc;
        bit          e;
        e  = (sz != 4'd8);
        ra = '0;
        rc = '0;
        if (!e) begin
            if (wr) begin
                if (a == B) begin
                    exp_a = d & MASK; exp_c = d & MASK;
                end else if (a == B + 16'd1) begin
                    exp_a = exp_a & d & MASK; exp_c = '0;
                end else if (a == B + 16'd2) begin
                    exp_a = (exp_a | d) & MASK; exp_c = (exp_c | d) & MASK;
                end
            end else if (a == B) begin
                ra = exp_a; rc = exp_c;
            end
        end
        @(negedge clk);
        chk({tag, " R10 ready idle"}, {62'd0, rdy_a, rdy_c}, 64'd3);
        chk({tag, " R10 no stray rsp"}, {62'd0, rv_a, rv_c}, 64'd0);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R10 rsp/ready"}, {60'd0, rv_a, rv_c, rdy_a, rdy_c}, 64'hC);
        chk({tag, " R9 err"}, {62'd0, err_a, err_c}, e ? 64'd3 : 64'd0);
        chk({tag, " rdata and-var"}, rd_a, ra);
        chk({tag, " rdata clr-var"}, rd_c, rc);
        chk({tag, " R6 irq"}, {62'd0, irq_a, irq_c}, {62'd0, exp_a[63], exp_c[63]});
    endtask

    task automatic readback(string tag);
        xfer(1'b0, B, 4'd8, 64'h0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 reset ready", {62'd0, rdy_a, rdy_c}, 64'd3);
        chk("R1 reset rsp", {62'd0, rv_a, rv_c}, 64'd0);
        chk("R1 reset irq", {62'd0, irq_a, irq_c}, 64'd0);
        rst_n = 1'b1;
        readback("R1 read after reset");

        // R2 load sweep, upper patterns with noise in low bits
        for (int i = 0; i < 256; i++) begin
            logic [63:0] d;
            d = {i[7:0], ~i[7:0], 48'h0} ^ {16'h0, 16'(i * 7), 32'hDEAD_BEEF};
            xfer(1'b1, B, 4'd8, d, "R2 load");
            readback("R2 readback");
        end

        // R3 OR and R4/R5 third alias sweeps, bit 63 toggled both ways
        for (int i = 0; i < 64; i++) begin
            logic [63:0] v, w;
            v = {16'(i * 16'h0B31), 48'h1234_5678_9ABC};
            w = {16'(16'hF00F ^ (i * 16'h2107)), 48'hFFFF_FFFF_FFFF};
            xfer(1'b1, B, 4'd8, v, "R2 preload");
            xfer(1'b1, B + 16'd2, 4'd8, w, "R3 or alias");
            readback("R3 readback");
            xfer(1'b1, B, 4'd8, v, "R2 preload");
            xfer(1'b1, B + 16'd1, 4'd8, w, "R4 R5 third alias");
            readback("R4 R5 readback");
        end

        // R6 explicit irq raise and drop
        xfer(1'b1, B, 4'd8, 64'h0, "R6 clear");
        xfer(1'b1, B + 16'd2, 4'd8, 64'h8000_0000_0000_0000, "R6 raise via set");
        xfer(1'b1, B + 16'd1, 4'd8, 64'h7FFF_FFFF_FFFF_FFFF, "R6 drop via third");
        xfer(1'b1, B, 4'd8, 64'hFFFF_0000_0000_0001, "R6 raise via load");
        xfer(1'b1, B + 16'd1, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R5 clear ignores data");

        // R7 reads elsewhere, R8 writes outside the window
        xfer(1'b1, B, 4'd8, 64'hA5C3_0000_0000_0000, "R2 setup");
        for (int k = -4; k <= 6; k++) begin
            logic [15:0] a;
            a = B + 16'(k);
            if (a != B) xfer(1'b0, a, 4'd8, 64'h0, "R7 alias/other read");
            readback("R7 no side effect");
            if (k < 0 || k > 2) begin
                xfer(1'b1, a, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R8 unmapped write");
                readback("R8 unchanged");
            end
        end

        // R9 size sweep on every mapped address, reads and writes
        xfer(1'b1, B, 4'd8, 64'h8001_0000_0000_0000, "R2 setup");
        for (int s = 0; s < 16; s++) begin
            if (s != 8) begin
                for (int k = 0; k < 3; k++) begin
                    xfer(1'b1, B + 16'(k), 4'(s), 64'h0, "R9 bad size write");
                    xfer(1'b0, B + 16'(k), 4'(s), 64'h0, "R9 bad size read");
                end
                readback("R9 unchanged");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule